// File: doc/BRIEF.md
# Function-Select Arithmetic/Logic Unit

A purely combinational arithmetic/logic unit of parameterizable width. It is built from one identical cell per bit. Each cell holds a full adder and a small logic selector. A three-bit function select and a carry input choose the operation.

When the top select bit is clear, the unit runs in arithmetic mode. The two low select bits steer the adder's second operand to one of four values: zero, B, the complement of B, or all ones. The carry input then enters bit 0 of the adder. Because of this, the single carry input doubles the set of arithmetic functions. With it the unit provides transfer, increment, add, add-with-carry, subtract-with-borrow, subtract and decrement.

When the top select bit is set, the same cells produce one of four bitwise logic results, and the carry input has no effect. The carry network between the cells is a parameter choice. It is either a plain ripple chain or a grouped lookahead, and both give identical outputs.

Top module: `fsalu`

## Requirements
- R1: With `fsel` = 3'b000, `result` is `opa` when `carry_in` = 0 and `opa + 1` (mod 2^WIDTH) when `carry_in` = 1.
- R2: With `fsel` = 3'b001, `result` is `opa + opb` when `carry_in` = 0 and `opa + opb + 1` when `carry_in` = 1 (mod 2^WIDTH).
- R3: With `fsel` = 3'b010, `result` is `opa - opb - 1` when `carry_in` = 0 and `opa - opb` when `carry_in` = 1 (mod 2^WIDTH).
- R4: With `fsel` = 3'b011, `result` is `opa - 1` (mod 2^WIDTH) when `carry_in` = 0 and `opa` when `carry_in` = 1.
- R5: With `fsel` = 3'b100, `result` is `opa | opb`; with `fsel` = 3'b101, `result` is `opa ^ opb`; in both cases `carry_in` has no effect on either output.
- R6: With `fsel` = 3'b110, `result` is `opa & opb`; with `fsel` = 3'b111, `result` is `~opa`; in both cases `carry_in` has no effect on either output.
- R7: When `fsel[2]` = 0, `carry_out` is bit WIDTH of the (WIDTH+1)-bit sum `opa + Y + carry_in`. Y is all zeros for `fsel[1:0]` = 00, `opb` for 01, `~opb` for 10 and all ones for 11.
- R8: When `fsel[2]` = 1, `carry_out` is 0.
- R9: The ripple carry variant (`LOOKAHEAD` = 0) and the grouped lookahead variant (`LOOKAHEAD` = 1) give identical `result` and `carry_out` for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| fsel | input | 3 | Function select; bit 2 picks logic mode |
| carry_in | input | 1 | Carry into bit 0 in arithmetic mode; ignored in logic mode |
| result | output | WIDTH | Function result |
| carry_out | output | 1 | Carry out of the top bit in arithmetic mode, 0 in logic mode |

## Verification
The block holds no state, so any fault in operand steering, a cell's gating or the carry network shows at the ports in the same evaluation as the input that excites it. A wrong steering code corrupts the result for one pair of select codes on almost every operand. A broken carry link shows only when the operands propagate a carry across that bit, so the stimulus mixes all-ones, sign-boundary and random operands under every select and carry-in combination. A second instance with the other carry structure must agree with the first on every vector.

// File: rtl/fsalu_pkg.sv
package fsalu_pkg;

   // Select field layout: bit 2 chooses logic mode, bits 1:0 pick the function.
   localparam int unsigned SEL_W = 3;
   typedef logic [SEL_W-1:0] fsel_t;

   // Operand steering codes for arithmetic mode (fsel[1:0])
   localparam logic [1:0] STEER_ZERO = 2'b00;
   localparam logic [1:0] STEER_B    = 2'b01;
   localparam logic [1:0] STEER_NB   = 2'b10;
   localparam logic [1:0] STEER_ONES = 2'b11;

   // Logic function codes (fsel[1:0] when fsel[2] = 1)
   localparam logic [1:0] LOG_OR   = 2'b00;
   localparam logic [1:0] LOG_XOR  = 2'b01;
   localparam logic [1:0] LOG_AND  = 2'b10;
   localparam logic [1:0] LOG_NOTA = 2'b11;

   function automatic logic is_logic_mode(input fsel_t s);
      return s[SEL_W-1];
   endfunction

endpackage

// File: rtl/fsalu_cell.sv
module fsalu_cell
   import fsalu_pkg::*;
(
   input  logic  a_bit,
   input  logic  b_bit,
   input  fsel_t sel,
   input  logic  c_bit,
   output logic  prop,
   output logic  gen,
   output logic  r_bit
);

   logic y_bit;
   logic sum_bit;
   logic log_bit;

   // Second adder operand steered by the low select bits
   always_comb begin
      unique case (sel[1:0])
         STEER_ZERO: y_bit = 1'b0;
         STEER_B:    y_bit = b_bit;
         STEER_NB:   y_bit = ~b_bit;
         default:    y_bit = 1'b1;
      endcase
   end

   assign prop    = a_bit ^ y_bit;
   assign gen     = a_bit & y_bit;
   assign sum_bit = prop ^ c_bit;

   always_comb begin
      unique case (sel[1:0])
         LOG_OR:   log_bit = a_bit | b_bit;
         LOG_XOR:  log_bit = a_bit ^ b_bit;
         LOG_AND:  log_bit = a_bit & b_bit;
         default:  log_bit = ~a_bit;
      endcase
   end

   assign r_bit = is_logic_mode(sel) ? log_bit : sum_bit;

endmodule

// File: rtl/fsalu_carry.sv
module fsalu_carry #(
   parameter int unsigned WIDTH     = 8,
   parameter int unsigned GROUP     = 4,
   parameter bit          LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] prop,
   input  logic [WIDTH-1:0] gen,
   input  logic             c0,
   output logic [WIDTH:0]   carry
);

   assign carry[0] = c0;

   if (!LOOKAHEAD) begin : g_ripple
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
      end
   end else begin : g_cla
      localparam int unsigned NGRP = WIDTH / GROUP;

      if (GROUP < 1) begin : g_bad_group
         $error("fsalu_carry: GROUP must be at least 1");
      end
      if ((WIDTH % GROUP) != 0) begin : g_bad_split
         $error("fsalu_carry: WIDTH must be a multiple of GROUP");
      end

      logic [NGRP:0] cgrp;
      assign cgrp[0] = c0;

      for (genvar k = 0; k < NGRP; k++) begin : g_grp
         localparam int unsigned BASE = k * GROUP;
         logic grp_p;
         logic grp_g;

         always_comb begin
            grp_p = 1'b1;
            grp_g = 1'b0;
            for (int j = 0; j < int'(GROUP); j++) begin
               grp_g = gen[BASE+j] | (prop[BASE+j] & grp_g);
               grp_p = grp_p & prop[BASE+j];
            end
         end

         // Group carry skips the inner ripple
         assign cgrp[k+1]          = grp_g | (grp_p & cgrp[k]);
         assign carry[BASE+GROUP]  = cgrp[k+1];

         for (genvar j = 0; j + 1 < GROUP; j++) begin : g_in
            assign carry[BASE+j+1] = gen[BASE+j] | (prop[BASE+j] & carry[BASE+j]);
         end
      end
   end

endmodule

// File: rtl/fsalu.sv
module fsalu
   import fsalu_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter int unsigned GROUP     = 4,
   parameter bit          LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [2:0]       fsel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("fsalu: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] prop;
   logic [WIDTH-1:0] gen;
   logic [WIDTH:0]   carry;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      fsalu_cell u_cell (
         .a_bit (opa[i]),
         .b_bit (opb[i]),
         .sel   (fsel),
         .c_bit (carry[i]),
         .prop  (prop[i]),
         .gen   (gen[i]),
         .r_bit (result[i])
      );
   end

   fsalu_carry #(
      .WIDTH     (WIDTH),
      .GROUP     (GROUP),
      .LOOKAHEAD (LOOKAHEAD)
   ) u_carry (
      .prop  (prop),
      .gen   (gen),
      .c0    (carry_in),
      .carry (carry)
   );

   assign carry_out = is_logic_mode(fsel) ? 1'b0 : carry[WIDTH];

endmodule

// File: rtl/fsalu_props.sv
module fsalu_props #(
   parameter int unsigned WIDTH = 8
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic [2:0]       fsel,
   input logic             carry_in,
   input logic [WIDTH-1:0] result,
   input logic             carry_out
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_comb begin
      // R8: no carry out of logic mode
      a_r8_logic_no_carry: assert (!(fsel[2] && carry_out))
         else $error("carry_out set in logic mode");
      // R1: transfer
      a_r1_transfer: assert (!(fsel == 3'b000 && !carry_in) || result == opa)
         else $error("transfer mismatch");
      // R4: decrement
      a_r4_decrement: assert (!(fsel == 3'b011 && !carry_in) || result == opa - ONE)
         else $error("decrement mismatch");
      // R6: complement of A
      a_r6_complement: assert (!(fsel == 3'b111) || (result ^ opa) == '1)
         else $error("complement mismatch");
      // R5: OR never clears a set operand bit
      a_r5_or_cover: assert (!(fsel == 3'b100) || (result & (opa | opb)) == (opa | opb))
         else $error("OR result loses operand bits");
   end

endmodule

bind fsalu fsalu_props #(.WIDTH(WIDTH)) u_props (
   .opa       (opa),
   .opb       (opb),
   .fsel      (fsel),
   .carry_in  (carry_in),
   .result    (result),
   .carry_out (carry_out)
);

// File: tb/fsalu_tb.sv
module fsalu_tb;

   localparam int unsigned W = 8;

   logic         clk = 1'b0;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic [2:0]   fsel = 3'b000;
   logic         carry_in = 1'b0;
   logic [W-1:0] result, result_rip;
   logic         carry_out, carry_out_rip;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fsalu #(.WIDTH(W), .GROUP(4), .LOOKAHEAD(1'b1)) u_dut (
      .opa(opa), .opb(opb), .fsel(fsel), .carry_in(carry_in),
      .result(result), .carry_out(carry_out));

   fsalu #(.WIDTH(W), .GROUP(4), .LOOKAHEAD(1'b0)) u_dut_rip (
      .opa(opa), .opb(opb), .fsel(fsel), .carry_in(carry_in),
      .result(result_rip), .carry_out(carry_out_rip));

   function automatic logic [W-1:0] exp_result(input logic [W-1:0] a, input logic [W-1:0] b,
                                                input logic [2:0] s, input logic c);
      logic [W-1:0] one = W'(1);
      case (s)
         3'b000: return c ? a + one : a;
         3'b001: return c ? a + b + one : a + b;
         3'b010: return c ? a - b : a - b - one;
         3'b011: return c ? a : a - one;
         3'b100: return a | b;
         3'b101: return a ^ b;
         3'b110: return a & b;
         default: return ~a;
      endcase
   endfunction

   function automatic logic exp_carry(input logic [W-1:0] a, input logic [W-1:0] b,
                                      input logic [2:0] s, input logic c);
      logic [W-1:0] y;
      logic [W:0]   wide;
      if (s[2]) return 1'b0;
      case (s[1:0])
         2'b00:   y = '0;
         2'b01:   y = b;
         2'b10:   y = ~b;
         default: y = '1;
      endcase
      wide = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, c};
      return wide[W];
   endfunction

   function automatic string res_tag(input logic [2:0] s);
      case (s)
         3'b000: return "R1";
         3'b001: return "R2";
         3'b010: return "R3";
         3'b011: return "R4";
         3'b100, 3'b101: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: sel=%b cin=%b a=%h b=%h got %h expected %h",
                  tag, fsel, carry_in, opa, opb, got, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [2:0] s, input logic c);
      @(negedge clk);
      opa = a; opb = b; fsel = s; carry_in = c;
      #2;
      check(res_tag(s), result, exp_result(a, b, s, c));
      check(s[2] ? "R8" : "R7", W'(carry_out), W'(exp_carry(a, b, s, c)));
      check("R9", result_rip, result);
      check("R9", W'(carry_out_rip), W'(carry_out));
   endtask

   localparam logic [W-1:0] CORNERS [6] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'h55};

   initial begin
      void'($urandom(32'd20240607));
      // Initial state: all-zero inputs give zero result and no carry
      #5;
      check("R1", result, '0);
      check("R7", W'(carry_out), '0);

      // Directed corners: every select and carry-in over boundary operands
      for (int ia = 0; ia < 6; ia++)
         for (int ib = 0; ib < 6; ib++)
            for (int s = 0; s < 8; s++)
               for (int c = 0; c < 2; c++)
                  apply(CORNERS[ia], CORNERS[ib], 3'(s), 1'(c));

      // R5/R6: carry-in ignored in logic mode, same operands both ways
      for (int s = 4; s < 8; s++) begin
         apply(8'hC3, 8'h5A, 3'(s), 1'b0);
         apply(8'hC3, 8'h5A, 3'(s), 1'b1);
      end

      // Constrained random sweep
      for (int n = 0; n < 3000; n++)
         apply(W'($urandom), W'($urandom), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule